// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Size

This block holds a small set of address translations and turns a 32-bit effective address, together with the current 8-bit process tag, into a 32-bit real address within the same cycle. Every slot may hold any translation. Each slot has its own page size, from 4 KB to 256 MB in steps of four. As a result the number of address bits that take part in the compare, and the number that are replaced by the real page number, differ from slot to slot. A slot whose process tag is zero is global and matches any current process. With a hit, the block also returns the slot index, a little-endian flag and a small set of access attributes for the page.

A management side lets software write a whole slot by index, read a slot back by index and search the buffer by address and process tag. A separate search port is provided so that a search never disturbs the translation port. A single-cycle bulk invalidate drops every slot that is not marked as flush-protected. The block is meant to sit between the load/store address generator and the bus. The fault logic and the page-table walker that refill it live elsewhere.

Top module: `tlb_assoc_xlate`

## Requirements
- R1: While rst_n is low at a clock edge, every slot is cleared. After reset, every read-back shows valid=0 and every translation misses.
- R2: A write with wr_en=1 replaces slot wr_idx with all the wr_* fields at the next rising edge. A translation or read in the cycle of the write still sees the old contents. A read-back after the edge returns exactly the fields that were written.
- R3: The size code sets the page size. A code c in 1..9 gives a page offset of 10+2c bits (1=4 KB, 2=16 KB, … 9=256 MB). Only the address bits above the offset are compared with the slot's effective page field. Codes 0 and 10..15 never match.
- R4: On a hit, the real address takes the bits above the page offset from the slot's real page field and the offset bits from the effective address.
- R5: A slot matches only when its process tag equals xl_pid, or when its process tag is 0 (global).
- R6: When several slots match, the lowest-indexed one is reported, along with its address and attributes.
- R7: On a miss, xl_miss=1 and xl_hit=0, and xl_ra, xl_idx, xl_le and xl_attr are all zero. On a hit, xl_hit=1 and xl_miss=0.
- R8: On a hit, xl_le equals the slot's byte-order bit (1 = little-endian, 0 = big-endian) and xl_attr equals the slot's 4-bit attribute field.
- R9: The search port applies the match rules of R3 and R5 to srch_ea/srch_pid. It returns srch_found=1 with the lowest matching index, or srch_found=0 with srch_idx=0.
- R10: A cycle with flush_all=1 clears the valid bit of every slot whose protect bit is 0. Protected slots stay valid. Fields other than valid are unchanged.
- R11: When wr_en and flush_all are both high in the same cycle, slot wr_idx takes the written values, including the written valid bit. All other slots are flushed as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_ea | input | 32 | Effective address to translate |
| xl_pid | input | 8 | Current process tag for translation |
| xl_hit | output | 1 | Translation hit |
| xl_miss | output | 1 | Translation miss |
| xl_ra | output | 32 | Real address (0 on miss) |
| xl_idx | output | 4 | Index of the hitting slot (0 on miss) |
| xl_le | output | 1 | Page is little-endian (0 on miss) |
| xl_attr | output | 4 | Page attributes (0 on miss) |
| srch_ea | input | 32 | Effective address to search for |
| srch_pid | input | 8 | Process tag for the search |
| srch_found | output | 1 | Search found a slot |
| srch_idx | output | 4 | Lowest matching slot (0 if none) |
| wr_en | input | 1 | Write slot wr_idx at the next edge |
| wr_idx | input | 4 | Slot to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_prot | input | 1 | Flush-protect bit to write |
| wr_pid | input | 8 | Process tag to write |
| wr_size | input | 4 | Page size code to write |
| wr_epn | input | 32 | Effective page field to write |
| wr_rpn | input | 32 | Real page field to write |
| wr_le | input | 1 | Byte-order bit to write |
| wr_attr | input | 4 | Attribute field to write |
| rd_idx | input | 4 | Slot to read back |
| rd_valid | output | 1 | Read-back valid bit |
| rd_prot | output | 1 | Read-back protect bit |
| rd_pid | output | 8 | Read-back process tag |
| rd_size | output | 4 | Read-back size code |
| rd_epn | output | 32 | Read-back effective page field |
| rd_rpn | output | 32 | Read-back real page field |
| rd_le | output | 1 | Read-back byte-order bit |
| rd_attr | output | 4 | Read-back attribute field |
| flush_all | input | 1 | Invalidate all unprotected slots at the next edge |

## Verification
The hardest case to reach from the ports is a tie among many slots. All sixteen slots are loaded with one page, and the slots are then retired one at a time from the bottom, so that each index in turn becomes the lowest winner against fifteen or fewer rivals. The per-slot compare mask is reached by sweeping all sixteen size codes over a single slot. For each code the bench probes the first and last byte of the page and the bytes just outside it on both sides, so that an off-by-one in the mask width shows up at once. A write and a bulk flush that land in the same cycle form the other rare case; the bench drives both together and reads every slot back.

// File: rtl/tlb_xlate_pkg.sv
// Package: shared widths, slot record and page-size decode for the
// translation buffer. Assumes page sizes are powers of four starting at
// MIN_PG_SHIFT and that the size code is a small unsigned field.
package tlb_xlate_pkg;

    localparam int EA_W         = 32;
    localparam int PID_W        = 8;
    localparam int SIZE_W       = 4;
    localparam int ATTR_W       = 4;
    localparam int MIN_PG_SHIFT = 12;
    localparam int MAX_SZ_CODE  = 9;

    // One buffer slot.
    typedef struct packed {
        logic              valid;
        logic              prot;
        logic [PID_W-1:0]  pid;
        logic [SIZE_W-1:0] size;
        logic [EA_W-1:0]   epn;
        logic [EA_W-1:0]   rpn;
        logic              le;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    // True for size codes that describe a real page size.
    function automatic logic sz_legal(input logic [SIZE_W-1:0] code);
        return (code >= SIZE_W'(1)) && (code <= SIZE_W'(MAX_SZ_CODE));
    endfunction

    // Mask of page-offset bits for a size code; illegal codes fall back
    // to the smallest page (they never match anyway).
    function automatic logic [EA_W-1:0] sz_off_mask(input logic [SIZE_W-1:0] code);
        int sh;
        sh = MIN_PG_SHIFT + 2 * (int'(code) - 1);
        if (!sz_legal(code)) sh = MIN_PG_SHIFT;
        return ~({EA_W{1'b1}} << sh);
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
// Slot storage: one register record per slot, written whole by index,
// with a bulk invalidate that spares protected slots. A write to a slot
// takes precedence over the bulk invalidate for that same slot.
// Assumes wr_idx is below NUM_ENTRIES when wr_en is high.
module tlb_entry_store
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic             flush_all,
    output tlb_ent_t         ent_q [NUM_ENTRIES]
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        // Update one slot: reset, whole-record write, or flush of valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (sel) begin
                ent_q[g] <= wr_ent;
            end else if (flush_all && !ent_q[g].prot) begin
                ent_q[g].valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tlb_entry_match.sv
// Per-slot comparator: decides whether one slot translates the given
// effective address for the given process tag. Only bits above the slot's
// own page offset are compared; a zero process tag is a wildcard.
// Assumes the slot record is stable for the whole cycle.
module tlb_entry_match
    import tlb_xlate_pkg::*;
(
    input  tlb_ent_t         ent,
    input  logic [EA_W-1:0]  ea,
    input  logic [PID_W-1:0] pid,
    output logic             hit
);

    logic [EA_W-1:0] off_mask;
    logic            page_eq;
    logic            pid_ok;

    // Compare page numbers under the slot's mask and check the tag.
    always_comb begin
        off_mask = sz_off_mask(ent.size);
        page_eq  = ((ea ^ ent.epn) & ~off_mask) == '0;
        pid_ok   = (ent.pid == '0) || (ent.pid == pid);
        hit      = ent.valid && sz_legal(ent.size) && page_eq && pid_ok;
    end

endmodule

// File: rtl/tlb_first_hit.sv
// Priority picker: reports whether any bit of a match vector is set and
// the index of the lowest set bit (zero when none is set).
module tlb_first_hit #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] match_vec,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    // Scan from the top down so the lowest set bit is the last written.
    always_comb begin
        found = |match_vec;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_assoc_xlate.sv
// Top: fully associative translation buffer with per-slot page size,
// process tag with global wildcard, per-page byte order and a
// flush-protect bit. Translation and search are combinational; writes and
// bulk invalidate land on the next rising edge. Assumes indices driven
// on wr_idx and rd_idx are below NUM_ENTRIES.
module tlb_assoc_xlate
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EA_W-1:0]   xl_ea,
    input  logic [PID_W-1:0]  xl_pid,
    output logic              xl_hit,
    output logic              xl_miss,
    output logic [EA_W-1:0]   xl_ra,
    output logic [IDX_W-1:0]  xl_idx,
    output logic              xl_le,
    output logic [ATTR_W-1:0] xl_attr,
    input  logic [EA_W-1:0]   srch_ea,
    input  logic [PID_W-1:0]  srch_pid,
    output logic              srch_found,
    output logic [IDX_W-1:0]  srch_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_prot,
    input  logic [PID_W-1:0]  wr_pid,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic [EA_W-1:0]   wr_epn,
    input  logic [EA_W-1:0]   wr_rpn,
    input  logic              wr_le,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_prot,
    output logic [PID_W-1:0]  rd_pid,
    output logic [SIZE_W-1:0] rd_size,
    output logic [EA_W-1:0]   rd_epn,
    output logic [EA_W-1:0]   rd_rpn,
    output logic              rd_le,
    output logic [ATTR_W-1:0] rd_attr,
    input  logic              flush_all
);

    tlb_ent_t               ent_q [NUM_ENTRIES];
    tlb_ent_t               wr_ent;
    logic [NUM_ENTRIES-1:0] xl_match_vec;
    logic [NUM_ENTRIES-1:0] srch_match_vec;
    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] prot_vec;
    logic                   xl_found;
    logic [IDX_W-1:0]       xl_first;
    tlb_ent_t               xl_sel;
    tlb_ent_t               rd_sel;
    logic [EA_W-1:0]        xl_mask;

    // Gather the write fields into one slot record.
    always_comb begin
        wr_ent.valid = wr_valid;
        wr_ent.prot  = wr_prot;
        wr_ent.pid   = wr_pid;
        wr_ent.size  = wr_size;
        wr_ent.epn   = wr_epn;
        wr_ent.rpn   = wr_rpn;
        wr_ent.le    = wr_le;
        wr_ent.attr  = wr_attr;
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_ent    (wr_ent),
        .flush_all (flush_all),
        .ent_q     (ent_q)
    );

    // Two comparator banks: one for translation, one for search.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        tlb_entry_match u_xl_m (
            .ent (ent_q[g]),
            .ea  (xl_ea),
            .pid (xl_pid),
            .hit (xl_match_vec[g])
        );
        tlb_entry_match u_srch_m (
            .ent (ent_q[g]),
            .ea  (srch_ea),
            .pid (srch_pid),
            .hit (srch_match_vec[g])
        );
        assign valid_vec[g] = ent_q[g].valid;
        assign prot_vec[g]  = ent_q[g].prot;
    end

    tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_xl_pick (
        .match_vec (xl_match_vec),
        .found     (xl_found),
        .idx       (xl_first)
    );

    tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_srch_pick (
        .match_vec (srch_match_vec),
        .found     (srch_found),
        .idx       (srch_idx)
    );

    // Build the translated address and attributes of the winning slot.
    always_comb begin
        xl_sel  = ent_q[xl_first];
        xl_mask = sz_off_mask(xl_sel.size);
        xl_hit  = xl_found;
        xl_miss = !xl_found;
        if (xl_found) begin
            xl_ra   = (xl_sel.rpn & ~xl_mask) | (xl_ea & xl_mask);
            xl_idx  = xl_first;
            xl_le   = xl_sel.le;
            xl_attr = xl_sel.attr;
        end else begin
            xl_ra   = '0;
            xl_idx  = '0;
            xl_le   = 1'b0;
            xl_attr = '0;
        end
    end

    // Read back one slot by index.
    always_comb begin
        rd_sel   = ent_q[rd_idx];
        rd_valid = rd_sel.valid;
        rd_prot  = rd_sel.prot;
        rd_pid   = rd_sel.pid;
        rd_size  = rd_sel.size;
        rd_epn   = rd_sel.epn;
        rd_rpn   = rd_sel.rpn;
        rd_le    = rd_sel.le;
        rd_attr  = rd_sel.attr;
    end

endmodule

// File: rtl/tlb_assoc_xlate_chk.sv
// Checker for tlb_assoc_xlate: watches the ports, the per-slot valid and
// protect bits and the comparator outputs. Attached to every instance of
// the top by the bind below.
module tlb_assoc_xlate_chk
    import tlb_xlate_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   xl_hit,
    input logic                   xl_miss,
    input logic [EA_W-1:0]        xl_ra,
    input logic [IDX_W-1:0]       xl_idx,
    input logic                   xl_le,
    input logic [ATTR_W-1:0]      xl_attr,
    input logic [NUM_ENTRIES-1:0] xl_match_vec,
    input logic                   srch_found,
    input logic [IDX_W-1:0]       srch_idx,
    input logic [NUM_ENTRIES-1:0] srch_match_vec,
    input logic [NUM_ENTRIES-1:0] valid_vec,
    input logic [NUM_ENTRIES-1:0] prot_vec,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx,
    input logic                   wr_valid,
    input logic                   flush_all
);

    logic [NUM_ENTRIES-1:0] xl_below;
    logic [NUM_ENTRIES-1:0] srch_below;
    assign xl_below   = (NUM_ENTRIES'(1) << xl_idx) - NUM_ENTRIES'(1);
    assign srch_below = (NUM_ENTRIES'(1) << srch_idx) - NUM_ENTRIES'(1);

    // R7
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit != xl_miss);

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_miss |-> (xl_ra == '0) && (xl_idx == '0) && !xl_le && (xl_attr == '0));

    // R6
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> xl_match_vec[xl_idx] && ((xl_match_vec & xl_below) == '0));

    // R9
    srch_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_found |-> srch_match_vec[srch_idx] && ((srch_match_vec & srch_below) == '0));

    // R2
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_vec[$past(wr_idx)] == $past(wr_valid));

    // R10
    flush_keep_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !wr_en) |=> valid_vec == $past(valid_vec & prot_vec));

endmodule

bind tlb_assoc_xlate tlb_assoc_xlate_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xl_hit         (xl_hit),
    .xl_miss        (xl_miss),
    .xl_ra          (xl_ra),
    .xl_idx         (xl_idx),
    .xl_le          (xl_le),
    .xl_attr        (xl_attr),
    .xl_match_vec   (xl_match_vec),
    .srch_found     (srch_found),
    .srch_idx       (srch_idx),
    .srch_match_vec (srch_match_vec),
    .valid_vec      (valid_vec),
    .prot_vec       (prot_vec),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .wr_valid       (wr_valid),
    .flush_all      (flush_all)
);

// File: tb/tlb_assoc_xlate_tb_top.sv
// Bench: keeps an arithmetic model of the slot contents and sweeps size
// codes, process tags, priority ties, flushes and same-cycle writes.
module tlb_assoc_xlate_tb_top;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] xl_ea = '0;
    logic [7:0]  xl_pid = '0;
    logic        xl_hit, xl_miss, xl_le;
    logic [31:0] xl_ra;
    logic [3:0]  xl_idx, xl_attr;
    logic [31:0] srch_ea = '0;
    logic [7:0]  srch_pid = '0;
    logic        srch_found;
    logic [3:0]  srch_idx;
    logic        wr_en = 1'b0, wr_valid = 1'b0, wr_prot = 1'b0, wr_le = 1'b0;
    logic [3:0]  wr_idx = '0, wr_size = '0, wr_attr = '0;
    logic [7:0]  wr_pid = '0;
    logic [31:0] wr_epn = '0, wr_rpn = '0;
    logic [3:0]  rd_idx = '0;
    logic        rd_valid, rd_prot, rd_le;
    logic [7:0]  rd_pid;
    logic [3:0]  rd_size, rd_attr;
    logic [31:0] rd_epn, rd_rpn;
    logic        flush_all = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model of slot contents.
    bit        m_v [N];
    bit        m_p [N];
    bit [7:0]  m_pid [N];
    bit [3:0]  m_sz [N];
    bit [31:0] m_epn [N];
    bit [31:0] m_rpn [N];
    bit        m_le [N];
    bit [3:0]  m_at [N];

    always #5 clk = ~clk;

    tlb_assoc_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .xl_ea(xl_ea), .xl_pid(xl_pid), .xl_hit(xl_hit), .xl_miss(xl_miss),
        .xl_ra(xl_ra), .xl_idx(xl_idx), .xl_le(xl_le), .xl_attr(xl_attr),
        .srch_ea(srch_ea), .srch_pid(srch_pid), .srch_found(srch_found), .srch_idx(srch_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_prot(wr_prot),
        .wr_pid(wr_pid), .wr_size(wr_size), .wr_epn(wr_epn), .wr_rpn(wr_rpn),
        .wr_le(wr_le), .wr_attr(wr_attr),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_prot(rd_prot), .rd_pid(rd_pid),
        .rd_size(rd_size), .rd_epn(rd_epn), .rd_rpn(rd_rpn), .rd_le(rd_le),
        .rd_attr(rd_attr), .flush_all(flush_all)
    );

    function automatic bit [31:0] pg_mask(input bit [3:0] sz);
        int sh;
        sh = (sz >= 1 && sz <= 9) ? 10 + 2 * int'(sz) : 12;
        return (32'h1 << sh) - 32'h1;
    endfunction

    function automatic bit slot_hits(input int i, input bit [31:0] ea, input bit [7:0] pid);
        bit [31:0] mk;
        mk = pg_mask(m_sz[i]);
        return m_v[i] && m_sz[i] >= 1 && m_sz[i] <= 9 &&
               ((ea & ~mk) == (m_epn[i] & ~mk)) &&
               (m_pid[i] == 8'h00 || m_pid[i] == pid);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive translate and search with one address; compare with the model.
    task automatic chk_xl(input bit [31:0] ea, input bit [7:0] pid, input string req);
        bit f;
        int w;
        logic [63:0] exp_v, act_v;
        xl_ea = ea; xl_pid = pid; srch_ea = ea; srch_pid = pid;
        #1;
        f = 1'b0; w = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (slot_hits(i, ea, pid)) begin f = 1'b1; w = i; end
        end
        if (f)
            exp_v = {22'b0, 1'b1, 1'b0, 4'(w), m_le[w], m_at[w],
                     (m_rpn[w] & ~pg_mask(m_sz[w])) | (ea & pg_mask(m_sz[w]))};
        else
            exp_v = {22'b0, 1'b0, 1'b1, 4'b0, 1'b0, 4'b0, 32'b0};
        act_v = {22'b0, xl_hit, xl_miss, xl_idx, xl_le, xl_attr, xl_ra};
        check(act_v === exp_v, req, act_v, exp_v);
        check({srch_found, srch_idx} === {f, 4'(f ? w : 0)}, "R9 search",
              64'({srch_found, srch_idx}), 64'({f, 4'(f ? w : 0)}));
    endtask

    task automatic chk_rd(input int i, input string req);
        logic [63:0] a, e;
        rd_idx = 4'(i);
        #1;
        a = {1'b0, rd_valid, rd_prot, rd_le, rd_pid, rd_size, rd_attr, rd_rpn[15:0], rd_epn[27:0]};
        e = {1'b0, 1'(m_v[i]), 1'(m_p[i]), 1'(m_le[i]), m_pid[i], m_sz[i], m_at[i],
             m_rpn[i][15:0], m_epn[i][27:0]};
        check(a === e && rd_epn === m_epn[i] && rd_rpn === m_rpn[i], req, a, e);
    endtask

    task automatic drive_wr(input int i, input bit v, input bit p, input bit [7:0] pid,
                            input bit [3:0] sz, input bit [31:0] epn, input bit [31:0] rpn,
                            input bit le, input bit [3:0] at);
        wr_idx = 4'(i); wr_valid = v; wr_prot = p; wr_pid = pid; wr_size = sz;
        wr_epn = epn; wr_rpn = rpn; wr_le = le; wr_attr = at; wr_en = 1'b1;
    endtask

    task automatic model_wr(input int i);
        m_v[i] = wr_valid; m_p[i] = wr_prot; m_pid[i] = wr_pid; m_sz[i] = wr_size;
        m_epn[i] = wr_epn; m_rpn[i] = wr_rpn; m_le[i] = wr_le; m_at[i] = wr_attr;
    endtask

    // Full write: set at a falling edge, commit on the rising edge.
    task automatic wr(input int i, input bit v, input bit p, input bit [7:0] pid,
                      input bit [3:0] sz, input bit [31:0] epn, input bit [31:0] rpn,
                      input bit le, input bit [3:0] at);
        @(negedge clk);
        drive_wr(i, v, p, pid, sz, epn, rpn, le, at);
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(i);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        bit [31:0] base, mk;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_p[i] = 0; m_pid[i] = 0; m_sz[i] = 0;
            m_epn[i] = 0; m_rpn[i] = 0; m_le[i] = 0; m_at[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        for (int i = 0; i < N; i++) chk_rd(i, "R1 reset readback");
        chk_xl(32'h0000_0000, 8'h00, "R1 reset miss");
        chk_xl(32'hDEAD_BEEF, 8'h5A, "R1 reset miss");

        // R3 R4 R8: sweep every size code over slot 5.
        for (int sz = 0; sz < 16; sz++) begin
            wr(5, 1, 0, 8'h21, 4'(sz), 32'hA5A5_A5A5, 32'h3C3C_3C3C, sz[0], 4'(sz));
            chk_rd(5, "R2 readback");
            mk = pg_mask(4'(sz));
            base = 32'hA5A5_A5A5 & ~mk;
            chk_xl(base, 8'h21, "R3 R4 R8 page start");
            chk_xl(base | mk, 8'h21, "R3 R4 R8 page end");
            chk_xl(base + mk + 32'h1, 8'h21, "R3 next page");
            chk_xl(base - 32'h1, 8'h21, "R3 previous page");
            chk_xl(base | (mk >> 1), 8'h22, "R5 tag mismatch");
        end
        wr(5, 0, 0, 8'h00, 4'd0, 32'h0, 32'h0, 0, 4'd0);

        // R5: process tag sweep on slot 1 including the global tag.
        foreach (m_v[k]) begin end
        for (int pi = 0; pi < 3; pi++) begin
            bit [7:0] tg;
            tg = (pi == 0) ? 8'h00 : (pi == 1) ? 8'h21 : 8'hFF;
            wr(1, 1, 0, tg, 4'd2, 32'h0040_0000, 32'h8000_0000, 1, 4'hA);
            chk_xl(32'h0040_1234, 8'h00, "R5 tag sweep");
            chk_xl(32'h0040_1234, 8'h21, "R5 tag sweep");
            chk_xl(32'h0040_1234, 8'h22, "R5 tag sweep");
            chk_xl(32'h0040_1234, 8'hFF, "R5 tag sweep");
        end
        wr(1, 0, 0, 8'h00, 4'd0, 32'h0, 32'h0, 0, 4'd0);

        // R6: every slot holds the same page; retire them from the bottom.
        for (int i = 0; i < N; i++)
            wr(i, 1, 0, 8'h00, 4'd1, 32'h1000_0000, 32'h2000_0000 + 32'(i) * 32'h1000, i[0], 4'(i));
        for (int i = 0; i < N; i++) begin
            chk_xl(32'h1000_0ABC, 8'h33, "R6 lowest wins");
            wr(i, 0, 0, 8'h00, 4'd1, 32'h1000_0000, 32'h0, 0, 4'd0);
        end
        chk_xl(32'h1000_0ABC, 8'h33, "R7 all retired");

        // R2: lookup in the cycle of a write sees the old slot.
        wr(0, 1, 0, 8'h00, 4'd1, 32'h0000_5000, 32'h0007_7000, 0, 4'h3);
        @(negedge clk);
        drive_wr(0, 1, 0, 8'h00, 4'd1, 32'h0000_5000, 32'h0009_9000, 1, 4'hC);
        chk_xl(32'h0000_5123, 8'h01, "R2 old contents in write cycle");
        chk_rd(0, "R2 old readback in write cycle");
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(0);
        chk_xl(32'h0000_5123, 8'h01, "R2 new contents after edge");
        chk_rd(0, "R2 new readback");

        // R10: bulk invalidate spares protected slots.
        for (int i = 0; i < N; i++)
            wr(i, 1, (i % 3) == 0, 8'(i), 4'd3, 32'(i) << 16, 32'hF000_0000 | (32'(i) << 16), 0, 4'(i));
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < N; i++) m_v[i] = m_v[i] & m_p[i];
        for (int i = 0; i < N; i++) chk_rd(i, "R10 flush readback");
        for (int i = 0; i < N; i++) chk_xl((32'(i) << 16) | 32'h0123, 8'(i), "R10 flush lookup");

        // R11: write and flush in the same cycle.
        for (int i = 0; i < N; i++)
            wr(i, 1, (i % 4) == 1, 8'h00, 4'd4, 32'(i) << 20, 32'(i) << 24, 1, 4'h7);
        @(negedge clk);
        drive_wr(6, 1, 0, 8'h00, 4'd4, 32'h0060_0000, 32'h0E00_0000, 0, 4'h2);
        flush_all = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        flush_all = 1'b0;
        for (int i = 0; i < N; i++) m_v[i] = m_v[i] & m_p[i];
        model_wr(6);
        for (int i = 0; i < N; i++) chk_rd(i, "R11 write beats flush");
        chk_xl(32'h0060_4321, 8'h09, "R11 written slot live");

        done = 1'b1;
        finish_run();
    end

endmodule